// File: doc/BRIEF.md
# Derived-Clock Write-Enable Pulse Narrower

This block turns a write-enable that a slow clock domain holds for one whole slow period into a strobe one fast-clock cycle wide. Both clocks come from a common source and their rising edges line up, with the fast clock an integer multiple of the slow one. Every flop in the block therefore samples signals that are settled, and no metastability synchronizer sits on the enable path. The narrowed strobe can drive a write port, a counter increment or any load enable in the fast domain, and it fires exactly once for each slow period in which the enable is high.

A parameter selects one of two ways to place the strobe. In counting mode the ratio is known at design time. A free-running modulo counter in the fast domain marks the last fast cycle of every slow period, and the strobe is issued there, which gives slow-domain data the most time to settle. In toggle mode the ratio is not known. The slow domain flips a feedback bit on every one of its rising edges, the fast domain compares that bit with its own registered copy, and the strobe lands in the first fast cycle of each slow period.

The external reset is asserted asynchronously. Its release is synchronized to the slow clock and shared by both domains, so the counter's zero state falls on a fast edge that coincides with a slow edge.

Top module: `derived_wen_narrower`

## Requirements
- R1: While `rst_n` is low, `fast_wen_pulse` is 0 whatever `slow_wen` does, and asserting `rst_n` clears the strobe without waiting for a clock edge.
- R2: After `rst_n` rises, the internal reset is released on the second rising edge of `clk_slow`. That edge starts slow period 0, and the fast-cycle index within a period counts from 0 at that edge.
- R3: Each strobe on `fast_wen_pulse` lasts exactly one `clk_fast` cycle.
- R4: In counting mode (MODE = NARROW_COUNT, encoding 0), a slow period in which `slow_wen` is 1 yields exactly one strobe, in fast-cycle index RATIO-1 (the last one), starting with slow period 0.
- R5: In counting mode, a slow period in which `slow_wen` is 0 yields no strobe.
- R6: In toggle mode (MODE = NARROW_TOGGLE, encoding 1), a slow period in which `slow_wen` is 1 yields exactly one strobe, in fast-cycle index 0, for every period from slow period 1 on. Back-to-back enabled periods each get their own strobe.
- R7: In toggle mode, a slow period in which `slow_wen` is 0 yields no strobe, and slow period 0 after a reset release yields no strobe even when `slow_wen` is 1.
- R8: In counting mode, `slow_wen` has held its value for at least the whole fast cycle before the strobe cycle.
- R9: Two strobes are at least RATIO fast cycles apart in counting mode and at least 2 fast cycles apart in toggle mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock, RATIO times the slow frequency, edge-aligned with it |
| clk_slow | input | 1 | Slow clock, derived from the same source as clk_fast |
| rst_n | input | 1 | Active-low asynchronous reset, released through a slow-domain synchronizer |
| slow_wen | input | 1 | Write-enable registered in the slow domain, held for a full slow period |
| fast_wen_pulse | output | 1 | Narrowed enable, one fast cycle per enabled slow period |

## Verification
One counting-mode instance and one toggle-mode instance, both with a ratio of four, receive the same slow-period enable sequence. The sequence includes long runs of enabled periods, so a missed or doubled strobe between adjacent periods shows up. Strictly alternating periods expose a strobe that leaks into a disabled period. Isolated single enabled periods separate a counter placed at the wrong phase from a correct one, because the bench records the exact fast-cycle index of every strobe. Two reset sequences, one of them cutting into a period with the enable high, show that the strobe is suppressed at once and that slow period 0 after each release is handled the way each mode requires.

// File: rtl/dwn_pkg.sv
`timescale 1ns/1ps
package dwn_pkg;

  // Strobe placement variant of the narrower.
  typedef enum logic [0:0] {
    NARROW_COUNT  = 1'b0,  // ratio known: strobe on last fast cycle of the slow period
    NARROW_TOGGLE = 1'b1   // ratio unknown: strobe on first fast cycle of the slow period
  } narrow_mode_e;

  // Width of a counter that wraps exactly at a power-of-two ratio.
  function automatic int unsigned phase_width(input int unsigned ratio);
    return (ratio < 2) ? 1 : $clog2(ratio);
  endfunction

endpackage

// File: rtl/dwn_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts immediately, deasserts on the STAGES-th clock edge.
module dwn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dwn_phase_count.sv
`timescale 1ns/1ps
// Fast-domain modulo counter; flags the last fast cycle of each slow period.
module dwn_phase_count #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk_fast,
  input  logic rst_n,
  output logic last_o
);

  localparam int unsigned CW = dwn_pkg::phase_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_d;
  logic          phase_en;

  // Free-running: power-of-two ratio lets the counter wrap on its own.
  always_comb begin
    phase_en = 1'b1;
    phase_d  = phase_q + CW'(1);
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign last_o = (phase_q == LAST);

endmodule

// File: rtl/dwn_toggle_detect.sv
`timescale 1ns/1ps
// Slow-side toggle feedback and fast-side transition detector.
module dwn_toggle_detect (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst_n,
  output logic first_o
);

  logic tog_q, tog_d;
  logic seen_q, seen_d;

  always_comb begin
    tog_d  = ~tog_q;
    seen_d = tog_q;
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  // Phase-related clocks: a single sampling flop sees a settled value.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  // Differs only during the fast cycle right after a slow edge.
  assign first_o = tog_q ^ seen_q;

endmodule

// File: rtl/derived_wen_narrower.sv
`timescale 1ns/1ps
module derived_wen_narrower #(
  parameter dwn_pkg::narrow_mode_e MODE       = dwn_pkg::NARROW_COUNT,
  parameter int unsigned           RATIO      = 4,  // power of two, at least 2
  parameter int unsigned           RST_STAGES = 2
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic slow_wen,
  output logic fast_wen_pulse
);

  logic blk_rst_n;
  logic slot_sel;

  // One release point, on a slow edge, shared by both domains.
  dwn_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk_slow),
    .arst_n (rst_n),
    .srst_n (blk_rst_n)
  );

  generate
    if (MODE == dwn_pkg::NARROW_COUNT) begin : g_count
      dwn_phase_count #(.RATIO(RATIO)) u_phase (
        .clk_fast (clk_fast),
        .rst_n    (blk_rst_n),
        .last_o   (slot_sel)
      );
    end else begin : g_toggle
      dwn_toggle_detect u_toggle (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst_n    (blk_rst_n),
        .first_o  (slot_sel)
      );
    end
  endgenerate

  assign fast_wen_pulse = slot_sel & slow_wen;

endmodule

// File: rtl/dwn_checker.sv
`timescale 1ns/1ps
module dwn_checker #(
  parameter dwn_pkg::narrow_mode_e MODE  = dwn_pkg::NARROW_COUNT,
  parameter int unsigned           RATIO = 4
) (
  input logic clk_fast,
  input logic rst_n,
  input logic slow_wen,
  input logic fast_wen_pulse
);

  localparam int unsigned MIN_GAP = (MODE == dwn_pkg::NARROW_COUNT) ? RATIO : 2;

  int unsigned since_q;
  logic        armed_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      armed_q <= 1'b0;
    end else if (fast_wen_pulse) begin
      since_q <= 1;
      armed_q <= 1'b1;
    end else if (since_q < MIN_GAP) begin
      since_q <= since_q + 1;
    end
  end

  always @(negedge clk_fast) begin
    if (!rst_n) begin
      AST_QUIET_IN_RESET: assert (!fast_wen_pulse) else $error("strobe during reset"); // R1
    end
  end

  AST_ONE_CYCLE_WIDE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    fast_wen_pulse |=> !fast_wen_pulse) else $error("strobe wider than one cycle"); // R3

  AST_MIN_SPACING: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (fast_wen_pulse && armed_q) |-> (since_q >= MIN_GAP)) else $error("strobes too close"); // R9

  generate
    if (MODE == dwn_pkg::NARROW_COUNT) begin : g_count_chk
      AST_WEN_SETTLED: assert property (@(posedge clk_fast) disable iff (!rst_n)
        fast_wen_pulse |-> $stable(slow_wen)) else $error("enable not settled"); // R8
    end
  endgenerate

endmodule

bind derived_wen_narrower dwn_checker #(.MODE(MODE), .RATIO(RATIO)) u_dwn_checker (
  .clk_fast       (clk_fast),
  .rst_n          (rst_n),
  .slow_wen       (slow_wen),
  .fast_wen_pulse (fast_wen_pulse)
);

// File: tb/derived_wen_narrower_bench.sv
`timescale 1ns/1ps
module derived_wen_narrower_bench;

  localparam int unsigned RATIO     = 4;
  localparam realtime     FAST_HALF = 2.5;
  localparam realtime     SLOW_HALF = 2.5 * RATIO;

  // {slow_wen, expected strobes counting mode, expected strobes toggle mode}
  localparam logic [2:0] VEC [0:11] = '{
    3'b111, 3'b111, 3'b111, 3'b000, 3'b111, 3'b000,
    3'b000, 3'b111, 3'b000, 3'b111, 3'b111, 3'b000
  };

  logic clk_fast, clk_slow, rst_n, slow_wen;
  logic pulse_cnt, pulse_tog;
  int   n_checks, n_fail;
  bit   finished;

  derived_wen_narrower #(.MODE(dwn_pkg::NARROW_COUNT), .RATIO(RATIO)) u_derived_wen_narrower (
    .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
    .slow_wen (slow_wen), .fast_wen_pulse (pulse_cnt)
  );

  derived_wen_narrower #(.MODE(dwn_pkg::NARROW_TOGGLE), .RATIO(RATIO)) u_derived_wen_narrower_tog (
    .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
    .slow_wen (slow_wen), .fast_wen_pulse (pulse_tog)
  );

  initial begin
    clk_fast = 1'b0;
    forever #(FAST_HALF) clk_fast = ~clk_fast;
  end

  initial begin
    clk_slow = 1'b0;
    #(FAST_HALF);
    clk_slow = 1'b1;
    forever #(SLOW_HALF) clk_slow = ~clk_slow;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a slow rising edge: drive the enable, then sample every fast cycle.
  task automatic run_period(input logic wen, output int cnt_c, output int pos_c,
                            output int cnt_t, output int pos_t);
    cnt_c = 0; pos_c = -1; cnt_t = 0; pos_t = -1;
    slow_wen = wen;
    for (int i = 0; i < int'(RATIO); i++) begin
      @(negedge clk_fast);
      if (pulse_cnt) begin cnt_c++; if (pos_c < 0) pos_c = i; end
      if (pulse_tog) begin cnt_t++; if (pos_t < 0) pos_t = i; end
    end
    @(posedge clk_slow);
    #1;
  endtask

  // Release reset just after a slow edge; return just after the internal release edge.
  task automatic release_reset();
    rst_n = 1'b1;
    @(posedge clk_slow);
    @(posedge clk_slow);
    #1;
  endtask

  initial begin
    #20000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int cc, pc, ct, pt;
    n_checks = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0;
    slow_wen = 1'b1;

    // R1: quiet during reset even with the enable high
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_fast);
      check("R1 count mode in reset", int'(pulse_cnt), 0);
      check("R1 toggle mode in reset", int'(pulse_tog), 0);
    end

    @(posedge clk_slow);
    #1;
    release_reset();

    // R2/R4/R7: slow period 0 after release
    run_period(1'b1, cc, pc, ct, pt);
    check("R2 R4 count mode strobes in period 0", cc, 1);
    check("R2 R4 count mode strobe index in period 0", pc, int'(RATIO) - 1);
    check("R7 toggle mode silent in period 0", ct, 0);

    // Table walk: R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      run_period(VEC[k][2], cc, pc, ct, pt);
      check("R3 R4 R5 count mode strobe count", cc, int'(VEC[k][1]));
      check("R4 count mode strobe index", pc, VEC[k][1] ? int'(RATIO) - 1 : -1);
      check("R3 R6 R7 toggle mode strobe count", ct, int'(VEC[k][0]));
      check("R6 toggle mode strobe index", pt, VEC[k][0] ? 0 : -1);
    end

    // R1: reset asserted in the middle of an enabled period
    rst_n = 1'b0;
    run_period(1'b1, cc, pc, ct, pt);
    check("R1 count mode after mid-run reset", cc, 0);
    check("R1 toggle mode after mid-run reset", ct, 0);

    // R2: second release realigns the counter; toggle mode again skips period 0
    release_reset();
    run_period(1'b1, cc, pc, ct, pt);
    check("R2 count mode strobes after re-release", cc, 1);
    check("R2 count mode index after re-release", pc, int'(RATIO) - 1);
    check("R7 toggle mode period 0 after re-release", ct, 0);
    run_period(1'b1, cc, pc, ct, pt);
    check("R4 count mode period 1 after re-release", pc, int'(RATIO) - 1);
    check("R6 toggle mode period 1 strobes", ct, 1);
    check("R6 toggle mode period 1 index", pt, 0);

    // R5 R7: enable low for a stretch
    for (int i = 0; i < 3; i++) begin
      run_period(1'b0, cc, pc, ct, pt);
      check("R5 count mode idle", cc, 0);
      check("R7 toggle mode idle", ct, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule